// File: doc/BRIEF.md
# Daisy-Chain Serial DAC Write Sequencer

This block is a host-side serial master. It writes one command into a chain of serial DACs that are wired in daisy-chain fashion. Every device in the chain shares the clock and data lines. The host drives the select of the first device only, and each device passes the select on to its neighbour after it has taken its own 24 bits. The user gives a target position in the chain, an 8-bit command code and a 16-bit payload, then pulses `start`.

The sequencer builds one 24-bit frame per device. The target device gets the real command and payload, and every other device gets a no-op frame. It lowers the select once for the whole burst, clocks out all frames back to back, and then raises the select again. After the select has stayed high for a programmable guard time, `done` pulses for one cycle.

The serial clock comes from the system clock through a divider of `HALF_CYC` cycles per half period. The defaults give about 20.8 MHz from a 125 MHz system clock, which is below the 25 MHz limit for a chain. The guard time is `GUARD_CYC` system cycles. The default of 5 cycles at 8 ns covers the 33 ns minimum high time of the select.

Top module: `chain_write_seq`

## Requirements
- R1: After reset, `csN` is 1, `sclk` is 0, `done` is 0, and the block is idle.
- R2: A `start` seen while idle is taken at the next rising clock edge. At that edge `csN` goes to 0, and it stays 0 without a break for all `NUM_DEV`×24 serial bits.
- R3: Each device frame is 24 bits: first the 8-bit command, then the 16-bit payload, and both are sent MSB first.
- R4: Frames follow chain order. Bits 0..23 of the burst go to position 0, which is the device nearest the host, bits 24..47 go to position 1, and so on. The position equal to `targetIdx` receives `cmdCode`/`payload`. Every other position receives command 0x00 with payload 0x0000.
- R5: `sclk` is 0 whenever `csN` is 1. During a burst, `sclk` is low for `HALF_CYC` cycles and then high for `HALF_CYC` cycles, once for each bit, and the low half comes first.
- R6: `sdo` changes during a burst only on a rising edge of `sclk`, and it holds its value across every falling edge. The first bit is already on `sdo` when `csN` falls.
- R7: `csN` rises `HALF_CYC` cycles after the last falling edge of `sclk`. It has then been high for at least `GUARD_CYC` cycles when `done` is asserted.
- R8: `done` is high for exactly one cycle, `GUARD_CYC` cycles after `csN` rises. A `start` presented in that same cycle is accepted.
- R9: A `start` that arrives during a burst or during the guard time is ignored. The frames already in flight do not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request a chain write (taken only while idle) |
| targetIdx | input | $clog2(NUM_DEV) | Chain position that receives the real command |
| cmdCode | input | 8 | Command code for the target device |
| payload | input | 16 | Data word for the target device |
| csN | output | 1 | Active-low select to the first device of the chain |
| sclk | output | 1 | Serial clock, idles low |
| sdo | output | 1 | Serial data, shared by all devices |
| done | output | 1 | One-cycle pulse once the guard time has elapsed |

## Verification
Two things can happen in the same cycle: the `done` strobe of one burst and the `start` of the next burst. The bench provokes this by raising `start` in the very cycle where `done` is seen. It then expects `csN` to fall at the next edge, after exactly `GUARD_CYC`+1 high cycles. A second case is a `start` with different operands in the middle of a burst. That case is judged by decoding the frames that each chain position samples on the falling edges of `sclk`, and the decoded frames must still match the first request.

// File: rtl/chain_seq_pkg.sv
package chain_seq_pkg;

  // Strobes from the sequencer control to the frame datapath.
  typedef struct packed {
    logic load;     // capture operands and present the first bit
    logic advance;  // present the next bit (rising serial clock)
  } seqStrobe_t;

endpackage

// File: rtl/chain_seq_datapath.sv
module chain_seq_datapath
  import chain_seq_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int CMD_W = 8,
  parameter int DATA_W = 16,
  parameter logic [CMD_W-1:0] NOP_CODE = '0,
  parameter int IDX_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [IDX_W-1:0]  targetIdx,
  input  logic [CMD_W-1:0]  cmdCode,
  input  logic [DATA_W-1:0] payload,
  output logic              sdo
);

  localparam int FRAME_W = CMD_W + DATA_W;
  localparam int BURST_W = NUM_DEV * FRAME_W;

  logic [BURST_W-1:0] burstWord;
  logic [BURST_W-1:0] shiftReg;
  logic               sdoQ;

  // Position 0 (nearest the host) sits in the most significant slot.
  for (genvar d = 0; d < NUM_DEV; d++) begin : g_slot
    assign burstWord[BURST_W-1-d*FRAME_W -: FRAME_W] =
      (targetIdx == IDX_W'(d)) ? {cmdCode, payload}
                               : {NOP_CODE, {DATA_W{1'b0}}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg <= '0;
      sdoQ     <= 1'b0;
    end else if (strobe.load) begin
      shiftReg <= burstWord;
      sdoQ     <= burstWord[BURST_W-1];
    end else if (strobe.advance) begin
      sdoQ     <= shiftReg[BURST_W-1];
      shiftReg <= {shiftReg[BURST_W-2:0], 1'b0};
    end
  end

  assign sdo = sdoQ;

endmodule

// File: rtl/chain_seq_ctrl.sv
module chain_seq_ctrl
  import chain_seq_pkg::*;
#(
  parameter int TOTAL_BITS = 96,
  parameter int HALF_CYC = 3,
  parameter int GUARD_CYC = 5
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  output seqStrobe_t strobe,
  output logic       csN,
  output logic       sclk,
  output logic       done
);

  localparam int CNT_MAX = (HALF_CYC > GUARD_CYC) ? HALF_CYC : GUARD_CYC;
  localparam int CNT_W = $clog2(CNT_MAX + 1);
  localparam int BIT_W = $clog2(TOTAL_BITS + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOW, ST_HIGH, ST_TAIL, ST_GUARD
  } seqState_t;

  seqState_t        state;
  logic [CNT_W-1:0] phaseCnt;
  logic [BIT_W-1:0] bitCnt;
  logic             halfEnd;
  logic             guardEnd;

  assign halfEnd  = (phaseCnt == CNT_W'(HALF_CYC - 1));
  assign guardEnd = (phaseCnt == CNT_W'(GUARD_CYC - 1));

  always_comb begin
    strobe.load    = (state == ST_IDLE) && start;
    strobe.advance = (state == ST_LOW) && halfEnd;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      bitCnt   <= '0;
      csN      <= 1'b1;
      sclk     <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (start) begin
            state    <= ST_LOW;
            phaseCnt <= '0;
            bitCnt   <= '0;
            csN      <= 1'b0;
          end
        end
        ST_LOW: begin
          if (halfEnd) begin
            phaseCnt <= '0;
            sclk     <= 1'b1;
            state    <= ST_HIGH;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_HIGH: begin
          if (halfEnd) begin
            phaseCnt <= '0;
            sclk     <= 1'b0;
            if (bitCnt == BIT_W'(TOTAL_BITS - 1)) begin
              state <= ST_TAIL;
            end else begin
              bitCnt <= bitCnt + 1'b1;
              state  <= ST_LOW;
            end
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_TAIL: begin
          if (halfEnd) begin
            phaseCnt <= '0;
            csN      <= 1'b1;
            state    <= ST_GUARD;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        ST_GUARD: begin
          if (guardEnd) begin
            phaseCnt <= '0;
            done     <= 1'b1;
            state    <= ST_IDLE;
          end else begin
            phaseCnt <= phaseCnt + 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/chain_write_seq.sv
module chain_write_seq
  import chain_seq_pkg::*;
#(
  parameter int NUM_DEV = 4,
  parameter int HALF_CYC = 3,
  parameter int GUARD_CYC = 5,
  parameter int CMD_W = 8,
  parameter int DATA_W = 16,
  parameter logic [CMD_W-1:0] NOP_CODE = '0,
  localparam int IDX_W = (NUM_DEV > 1) ? $clog2(NUM_DEV) : 1,
  localparam int TOTAL_BITS = NUM_DEV * (CMD_W + DATA_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [IDX_W-1:0]  targetIdx,
  input  logic [CMD_W-1:0]  cmdCode,
  input  logic [DATA_W-1:0] payload,
  output logic              csN,
  output logic              sclk,
  output logic              sdo,
  output logic              done
);

  seqStrobe_t seqStrobe;

  chain_seq_ctrl #(
    .TOTAL_BITS(TOTAL_BITS),
    .HALF_CYC(HALF_CYC),
    .GUARD_CYC(GUARD_CYC)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .strobe(seqStrobe), .csN(csN), .sclk(sclk), .done(done)
  );

  chain_seq_datapath #(
    .NUM_DEV(NUM_DEV), .CMD_W(CMD_W), .DATA_W(DATA_W),
    .NOP_CODE(NOP_CODE), .IDX_W(IDX_W)
  ) i_datapath (
    .clk(clk), .rstN(rstN), .strobe(seqStrobe),
    .targetIdx(targetIdx), .cmdCode(cmdCode), .payload(payload),
    .sdo(sdo)
  );

endmodule

// File: rtl/chain_write_seq_checker.sv
module chain_write_seq_checker (
  input logic clk,
  input logic rstN,
  input logic csN,
  input logic sclk,
  input logic sdo,
  input logic done
);

  // R5: serial clock rests low while deselected
  p_sclk_idle_r5: assert property (@(posedge clk) disable iff (!rstN)
    csN |-> !sclk);

  // R6: data holds across every falling serial clock edge
  p_sdo_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(sclk) |-> $stable(sdo));

  // R6: inside a burst, data moves only with a rising serial clock
  p_sdo_move_r6: assert property (@(posedge clk) disable iff (!rstN)
    (!csN && !$past(csN) && (sdo != $past(sdo))) |-> $rose(sclk));

  // R7: select rises with the serial clock already low
  p_cs_rise_low_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(csN) |-> !sclk);

  // R7: done arrives with the select high for more than one cycle
  p_done_guard_r7: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (csN && $past(csN)));

  // R8: done lasts a single cycle
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

endmodule

bind chain_write_seq chain_write_seq_checker i_checker (
  .clk(clk), .rstN(rstN), .csN(csN), .sclk(sclk), .sdo(sdo), .done(done)
);

// File: tb/test_chain_write_seq.sv
module test_chain_write_seq;

  localparam int NDEV  = 4;
  localparam int HALF  = 3;
  localparam int GUARD = 5;
  localparam int NBITS = NDEV * 24;
  localparam int LBURST = NBITS * 2 * HALF;
  localparam int ENDCYC = LBURST + HALF + GUARD;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [1:0] targetIdx = '0;
  logic [7:0] cmdCode = '0;
  logic [15:0] payload = '0;
  logic csN, sclk, sdo, done;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  // reference model state
  bit active = 1'b0;
  int cyc = 0;
  bit expBits[NBITS];
  bit rx[$];

  always #4 clk = ~clk;

  chain_write_seq #(.NUM_DEV(NDEV), .HALF_CYC(HALF), .GUARD_CYC(GUARD)) i_chain_write_seq (
    .clk(clk), .rstN(rstN), .start(start), .targetIdx(targetIdx),
    .cmdCode(cmdCode), .payload(payload),
    .csN(csN), .sclk(sclk), .sdo(sdo), .done(done)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h (t=%0t)", tag, act, exp, $time);
    end
  endtask

  function automatic bit [23:0] frameFor(input int pos, input int tgt,
                                         input bit [7:0] c, input bit [15:0] d);
    return (pos == tgt) ? {c, d} : 24'h000000;
  endfunction

  // model: one step per rising clock edge, from bench-driven inputs only
  always @(posedge clk) begin
    if (!rstN) begin
      active = 1'b0;
      cyc = 0;
    end else begin
      if (active) begin
        if (cyc == ENDCYC) active = 1'b0;
        else cyc++;
      end
      if (!active && start) begin
        active = 1'b1;
        cyc = 0;
        for (int k = 0; k < NBITS; k++) begin
          bit [23:0] f;
          f = frameFor(k / 24, int'(targetIdx), cmdCode, payload);
          expBits[k] = f[23 - (k % 24)];
        end
      end
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      bit eCs, eSclk, eDone, eSdo;
      int idx;
      eCs = 1'b1; eSclk = 1'b0; eDone = 1'b0; eSdo = 1'b0;
      if (active) begin
        eCs = !(cyc < LBURST + HALF);
        eSclk = (cyc < LBURST) ? bit'((cyc / HALF) % 2) : 1'b0;
        eDone = (cyc == ENDCYC);
        idx = (cyc < HALF) ? 0 : (cyc - HALF) / (2 * HALF);
        if (idx > NBITS - 1) idx = NBITS - 1;
        eSdo = expBits[idx];
      end
      check(csN === eCs, "R2/R7 csN", csN, eCs);
      check(sclk === eSclk, "R5 sclk", sclk, eSclk);
      check(done === eDone, "R8 done", done, eDone);
      if (!eCs) check(sdo === eSdo, "R6/R3 sdo", sdo, eSdo);
    end
  end

  // device-side view: bits taken on falling serial clock while selected
  always @(negedge sclk) if (csN === 1'b0) rx.push_back(sdo);

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog: actual %0d expected %0d cycles max", cycles, 150000);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic launch(input int tgt, input bit [7:0] c, input bit [15:0] d);
    targetIdx = 2'(tgt); cmdCode = c; payload = d; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic waitAndDecode(input int tgt, input bit [7:0] c, input bit [15:0] d);
    while (done !== 1'b1) @(negedge clk);
    check(rx.size() == NBITS, "R2 burst length", rx.size(), NBITS);
    for (int p = 0; p < NDEV; p++) begin
      bit [23:0] got, want;
      got = '0;
      for (int j = 0; j < 24; j++)
        if (p * 24 + j < rx.size()) got = {got[22:0], rx[p * 24 + j]};
      want = frameFor(p, tgt, c, d);
      check(got[23:16] == want[23:16], "R3/R4 command", got[23:16], want[23:16]);
      check(got[15:0] == want[15:0], "R3/R4 payload", got[15:0], want[15:0]);
    end
    rx.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    check(csN === 1'b1, "R1 csN idle", csN, 1);
    check(sclk === 1'b0, "R1 sclk idle", sclk, 0);
    check(done === 1'b0, "R1 done idle", done, 0);

    // R4: target at the first position
    launch(0, 8'h31, 16'hBEEF);
    waitAndDecode(0, 8'h31, 16'hBEEF);
    repeat (4) @(negedge clk);

    // R4: target at the last position
    launch(3, 8'h01, 16'h0F00);
    waitAndDecode(3, 8'h01, 16'h0F00);
    repeat (2) @(negedge clk);

    // R9: second start during the burst with other operands is ignored
    launch(1, 8'hFF, 16'hFFFF);
    repeat (60) @(negedge clk);
    launch(2, 8'h77, 16'h1234);
    waitAndDecode(1, 8'hFF, 16'hFFFF);
    @(negedge clk);
    check(csN === 1'b1, "R9 no extra burst", csN, 1);
    repeat (3) @(negedge clk);

    // R8: start in the same cycle as done is taken (back to back)
    launch(2, 8'hA5, 16'h5A5A);
    waitAndDecode(2, 8'hA5, 16'h5A5A);
    launch(1, 8'h3C, 16'h8001);
    check(csN === 1'b0, "R8 restart on done cycle", csN, 0);
    waitAndDecode(1, 8'h3C, 16'h8001);

    // R4: all-zero request at a middle position
    launch(2, 8'h00, 16'h0000);
    waitAndDecode(2, 8'h00, 16'h0000);
    repeat (5) @(negedge clk);
    check(csN === 1'b1 && sclk === 1'b0, "R1/R5 idle after runs", {csN, sclk}, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule